// File: doc/BRIEF.md
# Correction and Overlay Frame Timing Pulse Generator

This block produces the two timing strobes that start the convergence-correction and overlay address generators. A frame-start strobe is raised once per field, on a programmed count of regenerated horizontal sync edges after the vertical deflection flyback begins. A line-start strobe is raised on every line, on a programmed count of count-clock ticks after the regenerated horizontal sync edge. The line-start count sets the horizontal offset of overlays and correction maps. Vertical placement follows directly from the flyback reference.

The block also measures, on every line, how many ticks pass from the horizontal sync edge to the rising edge of the horizontal deflection flyback. It holds the result in a read-only value for the host. The clock is the count clock at 224 ticks per line. All inputs are synchronous to it.

Top module: `ovl_frame_timer`

## Requirements
- R1: During and right after a synchronous reset, `frame_start_n` and `line_start_n` are high and `phase_value` is 0.
- R2: A falling edge of `hsync_n` is taken at the first clock edge E0 that samples it low after it was sampled high. With `line_ticks` = N (1..255), `line_start_n` is low for exactly one cycle, the cycle that follows clock edge E_N, where E_k is the k-th clock edge after E0.
- R3: A new `hsync_n` falling edge before the pending line-start pulse discards that pulse and restarts the count. A `line_ticks` value of 0 produces no line-start pulse.
- R4: A rising edge of `vfly` arms the frame counter and clears it. With `frame_lines` = N (N ≥ 1), `frame_start_n` is low for exactly one cycle, the cycle after the clock edge that takes the N-th following `hsync_n` falling edge.
- R5: The frame-start pulse fires at most once per field. A `vfly` rising edge that arrives before N lines have been counted restarts the count, so no pulse is issued for that field. A `frame_lines` value of 0 never fires.
- R6: When `hfly` rises k ticks after the `hsync_n` edge, `phase_value` takes min(k, 223) at the clock edge E_k. k is counted in clock edges from E0, and k = 0 means `hfly` rises in the same cycle as the sync edge.
- R7: If a new `hsync_n` falling edge arrives while no `hfly` rising edge has been seen since the previous one, `phase_value` becomes all ones (255) at that edge. A phase of 224..254 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, 224 ticks per line |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | input | 1 | Regenerated horizontal sync, active low |
| vfly | input | 1 | Vertical flyback start, active high |
| hfly | input | 1 | Horizontal deflection flyback, active high |
| frame_lines | input | 10 | Sync edges to count before the frame-start pulse |
| line_ticks | input | 8 | Ticks to count before the line-start pulse |
| frame_start_n | output | 1 | Frame-start strobe, active low, one cycle |
| line_start_n | output | 1 | Line-start strobe, active low, one cycle |
| phase_value | output | 8 | Sync-to-flyback phase in ticks, 255 when flyback is missing |

## Verification
The frame-start strobe is due one cycle after the edge that takes the qualifying sync edge. The line-start strobe is due one cycle after edge E_N. A phase result is visible one cycle after edge E_k, and a missing-flyback flag one cycle after the next sync edge. The bench drives every input on the falling clock edge and samples on the falling edges that follow, so it records the exact falling-edge index at which each strobe is low. It compares that index against N+1 and confirms the strobe is low on no other index in the window. Phase checks sample at the first falling edge after E_k, which keeps the flyback offset and the expected value identical.

// File: rtl/ovl_timing_pkg.sv
package ovl_timing_pkg;

    localparam int TICK_W      = 8;
    localparam int LINE_CNT_W  = 10;
    localparam int PHASE_W     = 8;
    localparam int PHASE_LIMIT = 223;

    typedef enum logic {
        FR_IDLE  = 1'b0,
        FR_COUNT = 1'b1
    } frame_state_e;

    typedef struct packed {
        logic               busy;
        logic [PHASE_W-1:0] ticks;
    } phase_track_t;

    function automatic logic [PHASE_W-1:0] clamp_phase(input logic [PHASE_W-1:0] v);
        if (v > PHASE_W'(PHASE_LIMIT))
            return PHASE_W'(PHASE_LIMIT);
        return v;
    endfunction

endpackage

// File: rtl/ovl_edge_detect.sv
module ovl_edge_detect #(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic edge_o
);
    // Reset value chosen so no spurious edge appears just after reset.
    localparam logic RST_VAL = FALLING ? 1'b0 : 1'b1;

    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= din;
    end

    generate
        if (FALLING) begin : g_fall
            assign edge_o = prev & ~din;
        end else begin : g_rise
            assign edge_o = ~prev & din;
        end
    endgenerate

endmodule

// File: rtl/ovl_line_start.sv
module ovl_line_start #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hs_edge,
    input  logic [W-1:0] ticks,
    output logic         pulse_n
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic         armed;
    logic [W-1:0] cnt;
    logic         hit;

    assign hit = armed && (cnt == ticks);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            cnt     <= '0;
            pulse_n <= 1'b1;
        end else begin
            pulse_n <= ~hit;
            if (hs_edge) begin
                armed <= 1'b1;
                cnt   <= W'(1);
            end else if (armed) begin
                if (hit || cnt == CNT_MAX) armed <= 1'b0;
                else                       cnt   <= cnt + W'(1);
            end
        end
    end

    // A pulse only follows a nonzero programmed count (zero count suppresses).
    assert_zero_count_silent_R3: assert property (@(posedge clk) disable iff (rst)
        !pulse_n |-> $past(ticks) != '0);

    // With counts above one, the strobe never lasts two cycles.
    assert_line_pulse_width_R2: assert property (@(posedge clk) disable iff (rst)
        (!pulse_n && ticks > W'(1)) |=> pulse_n);

endmodule

// File: rtl/ovl_frame_start.sv
module ovl_frame_start
    import ovl_timing_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vf_edge,
    input  logic         hs_edge,
    input  logic [W-1:0] lines,
    output logic         pulse_n
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    frame_state_e state;
    logic [W-1:0] lcnt;
    logic [W:0]   next_cnt;

    assign next_cnt = {1'b0, lcnt} + (W+1)'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= FR_IDLE;
            lcnt    <= '0;
            pulse_n <= 1'b1;
        end else begin
            pulse_n <= 1'b1;
            if (vf_edge) begin
                state <= FR_COUNT;
                lcnt  <= '0;
            end else if (state == FR_COUNT && hs_edge) begin
                if (next_cnt == {1'b0, lines}) begin
                    pulse_n <= 1'b0;
                    state   <= FR_IDLE;
                end else if (lcnt == CNT_MAX) begin
                    state <= FR_IDLE;
                end else begin
                    lcnt <= next_cnt[W-1:0];
                end
            end
        end
    end

    assert_frame_on_sync_R4: assert property (@(posedge clk) disable iff (rst)
        !pulse_n |-> $past(hs_edge));

    assert_frame_pulse_width_R4: assert property (@(posedge clk) disable iff (rst)
        !pulse_n |=> pulse_n);

    // Once fired, no second pulse without a fresh flyback edge.
    assert_once_per_field_R5: assert property (@(posedge clk) disable iff (rst)
        (!pulse_n && !vf_edge) |=> state == FR_IDLE);

endmodule

// File: rtl/ovl_phase_meter.sv
module ovl_phase_meter
    import ovl_timing_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               hs_edge,
    input  logic               fly_edge,
    output logic [PHASE_W-1:0] phase
);
    localparam logic [PHASE_W-1:0] FLAG = {PHASE_W{1'b1}};

    phase_track_t trk;

    always_ff @(posedge clk) begin
        if (rst) begin
            trk   <= '0;
            phase <= '0;
        end else if (hs_edge) begin
            if (fly_edge) begin
                phase    <= '0;
                trk.busy <= 1'b0;
            end else begin
                if (trk.busy) phase <= FLAG;
                trk.busy <= 1'b1;
            end
            trk.ticks <= PHASE_W'(1);
        end else if (trk.busy) begin
            if (fly_edge) begin
                phase    <= clamp_phase(trk.ticks);
                trk.busy <= 1'b0;
            end else if (trk.ticks != FLAG) begin
                trk.ticks <= trk.ticks + PHASE_W'(1);
            end
        end
    end

    assert_phase_range_R7: assert property (@(posedge clk) disable iff (rst)
        (phase <= PHASE_W'(PHASE_LIMIT)) || (phase == FLAG));

    assert_missing_flyback_R7: assert property (@(posedge clk) disable iff (rst)
        (hs_edge && trk.busy && !fly_edge) |=> phase == FLAG);

    assert_phase_capture_R6: assert property (@(posedge clk) disable iff (rst)
        (fly_edge && trk.busy && !hs_edge) |=> phase == clamp_phase($past(trk.ticks)));

endmodule

// File: rtl/ovl_frame_timer.sv
module ovl_frame_timer
    import ovl_timing_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hsync_n,
    input  logic                  vfly,
    input  logic                  hfly,
    input  logic [LINE_CNT_W-1:0] frame_lines,
    input  logic [TICK_W-1:0]     line_ticks,
    output logic                  frame_start_n,
    output logic                  line_start_n,
    output logic [PHASE_W-1:0]    phase_value
);
    logic hs_edge;
    logic vf_edge;
    logic hf_edge;

    ovl_edge_detect #(.FALLING(1'b1)) u_hs_edge (
        .clk(clk), .rst(rst), .din(hsync_n), .edge_o(hs_edge));

    ovl_edge_detect #(.FALLING(1'b0)) u_vf_edge (
        .clk(clk), .rst(rst), .din(vfly), .edge_o(vf_edge));

    ovl_edge_detect #(.FALLING(1'b0)) u_hf_edge (
        .clk(clk), .rst(rst), .din(hfly), .edge_o(hf_edge));

    ovl_frame_start #(.W(LINE_CNT_W)) u_frame (
        .clk(clk), .rst(rst), .vf_edge(vf_edge), .hs_edge(hs_edge),
        .lines(frame_lines), .pulse_n(frame_start_n));

    ovl_line_start #(.W(TICK_W)) u_line (
        .clk(clk), .rst(rst), .hs_edge(hs_edge),
        .ticks(line_ticks), .pulse_n(line_start_n));

    ovl_phase_meter u_phase (
        .clk(clk), .rst(rst), .hs_edge(hs_edge),
        .fly_edge(hf_edge), .phase(phase_value));

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (frame_start_n && line_start_n && phase_value == '0));

endmodule

// File: tb/ovl_frame_timer_tb.sv
`timescale 1ns/1ps
module ovl_frame_timer_tb;
    import ovl_timing_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  hsync_n = 1'b1;
    logic                  vfly = 1'b0;
    logic                  hfly = 1'b0;
    logic [LINE_CNT_W-1:0] frame_lines = '0;
    logic [TICK_W-1:0]     line_ticks = '0;
    logic                  frame_start_n;
    logic                  line_start_n;
    logic [PHASE_W-1:0]    phase_value;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ovl_frame_timer u_dut (
        .clk(clk), .rst(rst), .hsync_n(hsync_n), .vfly(vfly), .hfly(hfly),
        .frame_lines(frame_lines), .line_ticks(line_ticks),
        .frame_start_n(frame_start_n), .line_start_n(line_start_n),
        .phase_value(phase_value));

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 frame_start_n in reset", int'(frame_start_n), 1);
        chk("R1 line_start_n in reset", int'(line_start_n), 1);
        chk("R1 phase in reset", int'(phase_value), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 strobes idle after reset", int'(frame_start_n & line_start_n), 1);
    endtask

    // R2/R3: one sync edge, record where the line strobe is low
    task automatic t_line(input string req, input int n, input int window,
                          input int exp_first, input int exp_lows);
        int first = -1;
        int lows  = 0;
        line_ticks = TICK_W'(n);
        @(negedge clk);
        hsync_n = 1'b0;
        for (int j = 1; j <= window; j++) begin
            @(negedge clk);
            if (!line_start_n) begin
                lows++;
                if (first < 0) first = j;
            end
            if (j == 2) hsync_n = 1'b1;
        end
        chk({req, " first low index"}, first, exp_first);
        chk({req, " low cycles"}, lows, exp_lows);
    endtask

    // R3: a second sync edge restarts the count
    task automatic t_line_restart();
        int first = -1;
        int lows  = 0;
        line_ticks = TICK_W'(6);
        @(negedge clk);
        hsync_n = 1'b0;
        for (int j = 1; j <= 20; j++) begin
            @(negedge clk);
            if (!line_start_n) begin
                lows++;
                if (first < 0) first = j;
            end
            if (j == 1) hsync_n = 1'b1;
            if (j == 3) hsync_n = 1'b0;
            if (j == 5) hsync_n = 1'b1;
        end
        chk("R3 restart first low index", first, 10);
        chk("R3 restart low cycles", lows, 1);
    endtask

    task automatic vfly_pulse();
        @(negedge clk);
        vfly = 1'b1;
        @(negedge clk);
        vfly = 1'b0;
    endtask

    task automatic hs_line(output bit low);
        @(negedge clk);
        hsync_n = 1'b0;
        @(negedge clk);
        low = !frame_start_n;
        hsync_n = 1'b1;
        repeat (3) @(negedge clk);
        if (!frame_start_n) low = 1'b1;
    endtask

    // R4/R5: count frame strobes over a run of lines
    task automatic t_frame(input string req, input int n, input int lines_a,
                           input int lines_b, input int exp_idx, input int exp_cnt);
        bit low;
        int idx = -1;
        int cnt = 0;
        frame_lines = LINE_CNT_W'(n);
        vfly_pulse();
        for (int i = 1; i <= lines_a; i++) begin
            hs_line(low);
            if (low) begin cnt++; if (idx < 0) idx = i; end
        end
        if (lines_b > 0) begin
            vfly_pulse();
            for (int i = 1; i <= lines_b; i++) begin
                hs_line(low);
                if (low) begin cnt++; if (idx < 0) idx = lines_a + i; end
            end
        end
        chk({req, " strobe line"}, idx, exp_idx);
        chk({req, " strobe count"}, cnt, exp_cnt);
    endtask

    // R6: flyback k ticks after the sync edge
    task automatic t_phase(input string req, input int k, input int exp);
        @(negedge clk);
        hsync_n = 1'b0;
        if (k == 0) hfly = 1'b1;
        for (int j = 1; j <= k; j++) begin
            @(negedge clk);
            if (j == 1) hsync_n = 1'b1;
            if (j == k) hfly = 1'b1;
        end
        @(negedge clk);
        chk(req, int'(phase_value), exp);
        hsync_n = 1'b1;
        hfly = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // R7: no flyback between two sync edges
    task automatic t_phase_missing();
        @(negedge clk);
        hsync_n = 1'b0;
        @(negedge clk);
        hsync_n = 1'b1;
        repeat (4) @(negedge clk);
        hsync_n = 1'b0;
        @(negedge clk);
        chk("R7 missing flyback flag", int'(phase_value), 255);
        hsync_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_line("R2 N=5", 5, 12, 6, 1);
        t_line("R2 N=1", 1, 8, 2, 1);
        t_line("R2 N=200", 200, 210, 201, 1);
        t_line("R3 N=0", 0, 270, -1, 0);
        t_line_restart();
        line_ticks = '0;
        t_frame("R4 N=3", 3, 6, 0, 3, 1);
        t_frame("R4 N=1", 1, 4, 0, 1, 1);
        t_frame("R5 once N=2", 2, 8, 0, 2, 1);
        t_frame("R5 early flyback N=8", 8, 5, 5, -1, 0);
        t_frame("R5 zero count", 0, 6, 0, -1, 0);
        t_phase("R6 phase k=0", 0, 0);
        t_phase("R6 phase k=1", 1, 1);
        t_phase("R6 phase k=37", 37, 37);
        t_phase("R6 phase k=223", 223, 223);
        t_phase("R6 phase saturate k=230", 230, 223);
        t_phase_missing();
        t_phase("R6 phase after flag k=12", 12, 12);
        finish_run();
    end

endmodule